// File: doc/BRIEF.md
# Resolver Converter Start-Up Output Sequencer

This block sits between the tracking and fault-detection logic of a resolver-to-digital converter and its data ports. It decides when the live angle and speed words and the fault results may be shown to the outside. After an accepted reset it drives the position and velocity outputs to zero and shows both fault flags as active. It then waits out a fixed settling window, counted in clock cycles, while the tracking loop locks onto the shaft angle.

The first sample strobe after that window copies the live position, velocity and fault results into the output registers and releases the fault flags. From then on, every sample strobe refreshes all four outputs on the same clock edge. The outputs hold their values between strobes. A reset request must stay low for a minimum number of cycles before it counts. A shorter glitch leaves the sequence and the outputs untouched.

Top module: `rdc_start_seq`

## Requirements
- R1: When `rstN` has been sampled low on RST_MIN_CYCLES consecutive rising edges, the reset is accepted. After that edge, `posOut` and `velOut` read 0.
- R2: The fault flags are active low (0 = fault, 1 = healthy). From an accepted reset until the first valid sample, `trackOkOut` and `signalOkOut` read 0.
- R3: If `rstN` is low on fewer than RST_MIN_CYCLES consecutive edges, the pulse is ignored. All outputs keep their previous values and later samples still refresh them.
- R4: After the reset is released, the block counts SETTLE_CYCLES edges as a settling window. A `sampleIn` pulse inside that window is ignored: the outputs stay at zero and the flags stay at 0.
- R5: The first `sampleIn` high on a rising edge after the window loads `posIn`, `velIn`, `trackOkIn` and `signalOkIn` into the outputs. The values are visible after that edge.
- R6: After release, every later `sampleIn` high on a rising edge loads the current inputs into all four outputs on that same edge.
- R7: On edges with `sampleIn` low, all four outputs hold their values.
- R8: A reset accepted after operation restarts the whole sequence. Outputs return to zero, the flags return to fault, and a new settling window is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Reset request, active low, width-filtered |
| sampleIn | input | 1 | Sample strobe, active high, taken on a rising edge |
| posIn | input | POS_W | Live angle word from the tracking loop |
| velIn | input | VEL_W | Live signed speed word from the tracking loop |
| trackOkIn | input | 1 | Fault detector: tracking healthy (0 = lost) |
| signalOkIn | input | 1 | Fault detector: input signal healthy (0 = degraded or lost) |
| posOut | output | POS_W | Latched angle word for the data ports |
| velOut | output | VEL_W | Latched speed word for the data ports |
| trackOkOut | output | 1 | Visible tracking flag (0 = fault) |
| signalOkOut | output | 1 | Visible signal flag (0 = fault) |

## Verification
The bench builds the block with SETTLE_CYCLES = 40 and RST_MIN_CYCLES = 4. These values stand in for the real 20 ms window and the 10 µs reset minimum. With them, the bench can reach the point where an early strobe is refused and the first strobe after the window is taken, all within a few dozen cycles. It can also reach the filter boundary, where a three-cycle low pulse is ignored and a four-cycle pulse is accepted. The directed tests show that the sequence restarts after a reset during operation.

// File: rtl/rdc_start_seq_pkg.sv
package rdc_start_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_ARMED  = 2'd2,
    SEQ_RUN    = 2'd3
  } seqState_t;

  // strobes from control to the output registers
  typedef struct packed {
    logic clearOut;
    logic loadOut;
  } outStb_t;

endpackage

// File: rtl/rdc_start_seq_ctrl.sv
module rdc_start_seq_ctrl
  import rdc_start_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES  = 163840,
  parameter int unsigned RST_MIN_CYCLES = 82
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleIn,
  output outStb_t   stb,
  output seqState_t state
);

  localparam int unsigned LOW_W = $clog2(RST_MIN_CYCLES + 1);
  localparam int unsigned SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(RST_MIN_CYCLES - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);

  logic [LOW_W-1:0] lowCnt;
  logic [SET_W-1:0] settleCnt;
  logic             rstAccept;

  // reset request counts only once held low long enough
  assign rstAccept = !rstN && (lowCnt == LOW_LAST);

  always_ff @(posedge clk) begin
    if (rstN) begin
      lowCnt <= '0;
    end else if (lowCnt != LOW_LAST) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstAccept) begin
      state     <= SEQ_HOLD;
      settleCnt <= '0;
    end else begin
      case (state)
        SEQ_HOLD: begin
          if (rstN) begin
            state     <= SEQ_SETTLE;
            settleCnt <= '0;
          end
        end
        SEQ_SETTLE: begin
          if (settleCnt == SET_LAST) begin
            state <= SEQ_ARMED;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        SEQ_ARMED: begin
          if (sampleIn) begin
            state <= SEQ_RUN;
          end
        end
        default: state <= SEQ_RUN;
      endcase
    end
  end

  always_comb begin
    stb.clearOut = rstAccept;
    stb.loadOut  = !rstAccept && sampleIn &&
                   ((state == SEQ_ARMED) || (state == SEQ_RUN));
  end

endmodule

// File: rtl/rdc_start_seq_dp.sv
module rdc_start_seq_dp
  import rdc_start_seq_pkg::*;
#(
  parameter int unsigned POS_W = 12,
  parameter int unsigned VEL_W = 12
) (
  input  logic             clk,
  input  outStb_t          stb,
  input  logic [POS_W-1:0] posIn,
  input  logic [VEL_W-1:0] velIn,
  input  logic             trackOkIn,
  input  logic             signalOkIn,
  output logic [POS_W-1:0] posOut,
  output logic [VEL_W-1:0] velOut,
  output logic             trackOkOut,
  output logic             signalOkOut
);

  always_ff @(posedge clk) begin
    if (stb.clearOut) begin
      posOut      <= '0;
      velOut      <= '0;
      trackOkOut  <= 1'b0;
      signalOkOut <= 1'b0;
    end else if (stb.loadOut) begin
      posOut      <= posIn;
      velOut      <= velIn;
      trackOkOut  <= trackOkIn;
      signalOkOut <= signalOkIn;
    end
  end

endmodule

// File: rtl/rdc_start_seq.sv
module rdc_start_seq
  import rdc_start_seq_pkg::*;
#(
  parameter int unsigned POS_W          = 12,
  parameter int unsigned VEL_W          = 12,
  parameter int unsigned SETTLE_CYCLES  = 163840,
  parameter int unsigned RST_MIN_CYCLES = 82
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleIn,
  input  logic [POS_W-1:0] posIn,
  input  logic [VEL_W-1:0] velIn,
  input  logic             trackOkIn,
  input  logic             signalOkIn,
  output logic [POS_W-1:0] posOut,
  output logic [VEL_W-1:0] velOut,
  output logic             trackOkOut,
  output logic             signalOkOut
);

  outStb_t   ctrlStb;
  seqState_t seqState;

  rdc_start_seq_ctrl #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .RST_MIN_CYCLES(RST_MIN_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sampleIn(sampleIn),
    .stb     (ctrlStb),
    .state   (seqState)
  );

  rdc_start_seq_dp #(
    .POS_W(POS_W),
    .VEL_W(VEL_W)
  ) u_dp (
    .clk        (clk),
    .stb        (ctrlStb),
    .posIn      (posIn),
    .velIn      (velIn),
    .trackOkIn  (trackOkIn),
    .signalOkIn (signalOkIn),
    .posOut     (posOut),
    .velOut     (velOut),
    .trackOkOut (trackOkOut),
    .signalOkOut(signalOkOut)
  );

endmodule

// File: rtl/rdc_start_seq_chk.sv
module rdc_start_seq_chk
  import rdc_start_seq_pkg::*;
#(
  parameter int unsigned POS_W = 12,
  parameter int unsigned VEL_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleIn,
  input logic [POS_W-1:0] posIn,
  input logic [VEL_W-1:0] velIn,
  input logic             trackOkIn,
  input logic             signalOkIn,
  input logic [POS_W-1:0] posOut,
  input logic [VEL_W-1:0] velOut,
  input logic             trackOkOut,
  input logic             signalOkOut,
  input seqState_t        seqState
);

  // R2 R8
  not_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState != SEQ_RUN) |-> (posOut == '0) && (velOut == '0) && !trackOkOut && !signalOkOut);

  // R4
  settle_no_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_SETTLE) |=> (seqState != SEQ_RUN));

  // R6
  load_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_RUN && sampleIn) |=>
      (posOut == $past(posIn)) && (velOut == $past(velIn)) &&
      (trackOkOut == $past(trackOkIn)) && (signalOkOut == $past(signalOkIn)));

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_RUN && !sampleIn) |=>
      $stable(posOut) && $stable(velOut) && $stable(trackOkOut) && $stable(signalOkOut));

  // R5
  first_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_ARMED && sampleIn) |=> (seqState == SEQ_RUN) && (posOut == $past(posIn)));

endmodule

bind rdc_start_seq rdc_start_seq_chk #(
  .POS_W(POS_W),
  .VEL_W(VEL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleIn   (sampleIn),
  .posIn      (posIn),
  .velIn      (velIn),
  .trackOkIn  (trackOkIn),
  .signalOkIn (signalOkIn),
  .posOut     (posOut),
  .velOut     (velOut),
  .trackOkOut (trackOkOut),
  .signalOkOut(signalOkOut),
  .seqState   (seqState)
);

// File: tb/rdc_start_seq_tb.sv
`timescale 1ns/1ps
module rdc_start_seq_tb;

  localparam int POS_W  = 12;
  localparam int VEL_W  = 12;
  localparam int SETTLE = 40;
  localparam int RSTMIN = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             sampleIn;
  logic [POS_W-1:0] posIn;
  logic [VEL_W-1:0] velIn;
  logic             trackOkIn;
  logic             signalOkIn;
  logic [POS_W-1:0] posOut;
  logic [VEL_W-1:0] velOut;
  logic             trackOkOut;
  logic             signalOkOut;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rdc_start_seq #(
    .POS_W(POS_W), .VEL_W(VEL_W),
    .SETTLE_CYCLES(SETTLE), .RST_MIN_CYCLES(RSTMIN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn),
    .posIn(posIn), .velIn(velIn),
    .trackOkIn(trackOkIn), .signalOkIn(signalOkIn),
    .posOut(posOut), .velOut(velOut),
    .trackOkOut(trackOkOut), .signalOkOut(signalOkOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkOuts(input string req, input logic [POS_W-1:0] p,
                         input logic [VEL_W-1:0] v, input logic t, input logic s);
    chk(req, "posOut", 32'(posOut), 32'(p));
    chk(req, "velOut", 32'(velOut), 32'(v));
    chk(req, "trackOkOut", 32'(trackOkOut), 32'(t));
    chk(req, "signalOkOut", 32'(signalOkOut), 32'(s));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle sample strobe with given live inputs
  task automatic pulse(input logic [POS_W-1:0] p, input logic [VEL_W-1:0] v,
                       input logic t, input logic s);
    posIn = p; velIn = v; trackOkIn = t; signalOkIn = s;
    sampleIn = 1'b1;
    @(negedge clk);
    sampleIn = 1'b0;
  endtask

  task automatic doReset(input int lowCycles);
    rstN = 1'b0;
    cycles(lowCycles);
    rstN = 1'b1;
  endtask

  task automatic t_reset_state;
    doReset(RSTMIN + 2);
    // R1 R2
    chkOuts("R1", '0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_early_sample;
    cycles(20);
    pulse(12'h123, 12'h045, 1'b1, 1'b1);
    // R4 strobe inside settle window ignored
    chkOuts("R4", '0, '0, 1'b0, 1'b0);
    cycles(3);
    chkOuts("R2", '0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_first_sample;
    cycles(SETTLE + 5);
    // R8 still zero before the first valid strobe
    chkOuts("R8", '0, '0, 1'b0, 1'b0);
    pulse(12'hA5C, 12'hF80, 1'b1, 1'b0);
    chkOuts("R5", 12'hA5C, 12'hF80, 1'b1, 1'b0);
  endtask

  task automatic t_repeat_sample;
    pulse(12'h001, 12'h7FF, 1'b0, 1'b1);
    chkOuts("R6", 12'h001, 12'h7FF, 1'b0, 1'b1);
    pulse(12'hFFF, 12'h800, 1'b1, 1'b1);
    chkOuts("R6", 12'hFFF, 12'h800, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    posIn = 12'h3C3; velIn = 12'h111; trackOkIn = 1'b0; signalOkIn = 1'b0;
    cycles(5);
    // R7 inputs moved without strobe
    chkOuts("R7", 12'hFFF, 12'h800, 1'b1, 1'b1);
  endtask

  task automatic t_short_reset;
    doReset(RSTMIN - 1);
    cycles(2);
    // R3 short low pulse filtered
    chkOuts("R3", 12'hFFF, 12'h800, 1'b1, 1'b1);
    pulse(12'h246, 12'h135, 1'b1, 1'b0);
    chkOuts("R3", 12'h246, 12'h135, 1'b1, 1'b0);
  endtask

  task automatic t_restart;
    rstN = 1'b0;
    cycles(RSTMIN);
    // R1 exactly the minimum width is accepted
    chkOuts("R1", '0, '0, 1'b0, 1'b0);
    rstN = 1'b1;
    cycles(5);
    pulse(12'h777, 12'h001, 1'b1, 1'b1);
    // R8 restarted sequence refuses an early strobe
    chkOuts("R8", '0, '0, 1'b0, 1'b0);
    cycles(SETTLE + 5);
    pulse(12'h777, 12'h001, 1'b1, 1'b1);
    chkOuts("R5", 12'h777, 12'h001, 1'b1, 1'b1);
  endtask

  initial begin
    rstN = 1'b1; sampleIn = 1'b0;
    posIn = '0; velIn = '0; trackOkIn = 1'b1; signalOkIn = 1'b1;
    cycles(2);
    t_reset_state();
    t_early_sample();
    t_first_sample();
    t_repeat_sample();
    t_hold();
    t_short_reset();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule